// File: doc/BRIEF.md
# Process Active-Node Tracker with Prewake

This block tracks, for every process slot, how many mapped pages it holds in each memory node. A node counts as active for a process while that count is above zero. The block keeps one active-node bitmask per process and updates it from map and unmap events as they arrive, one counter per event, so it never has to scan memory or page tables.

At a context switch the scheduler supplies two process ids: the one about to run and the one likely to run after it. One cycle later the block emits a wake pulse. The pulse carries the union of both processes' active nodes, restricted to the nodes that the power manager currently reports as napping. The power manager raises those nodes to standby, so the wake-up latency overlaps the rest of the switch. A combinational query port returns any process's current active mask.

Top module: `node_activity_tracker`

## Requirements
- R1: After reset every counter is zero, `qry_mask` reads zero for every process, and `wake_valid`, `wake_mask`, `err_ovf` and `err_unf` are zero.
- R2: A map event on a node whose count for that process is zero sets bit `map_node` of that process's mask, and `qry_mask` shows the bit after the next rising edge.
- R3: The node bit stays set while the count is above zero. It clears only on the unmap that brings the count from 1 to 0.
- R4: An unmap on a zero count leaves the count at zero and pulses `err_unf` high for one cycle, after the next edge.
- R5: Counters are CW bits wide (65535 at the default) and saturate at the top. A map on a full counter leaves it at 65535 and pulses `err_ovf` one cycle later.
- R6: Each (process, node) count is independent. An event on one entry changes no other process's mask and no other node's bit.
- R7: When a map and an unmap arrive in the same cycle, the unmap is applied first. On the same zero-count entry this flags `err_unf` and leaves the count at 1.
- R8: `sw_valid` makes `wake_valid` high in the next cycle. `wake_mask` then equals (mask of `sw_next_pid` OR mask of `sw_after_pid`) AND `nap_mask`, with `nap_mask` bit n set meaning node n is napping.
- R9: The masks used for the wake pulse already include any map or unmap accepted in the same cycle as `sw_valid`.
- R10: Nodes whose `nap_mask` bit is zero never appear in `wake_mask`.
- R11: `wake_valid` is high for exactly one cycle per switch. In a cycle that does not follow `sw_valid`, `wake_mask` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_valid | input | 1 | Page-map event |
| map_pid | input | PW | Process slot of the map event |
| map_node | input | NW | Node of the map event |
| unmap_valid | input | 1 | Page-unmap event |
| unmap_pid | input | PW | Process slot of the unmap event |
| unmap_node | input | NW | Node of the unmap event |
| sw_valid | input | 1 | Context-switch event |
| sw_next_pid | input | PW | Process about to run |
| sw_after_pid | input | PW | Process likely to run after it |
| nap_mask | input | NNODE | Nodes currently napping |
| qry_pid | input | PW | Process to query |
| qry_mask | output | NNODE | Active-node mask of `qry_pid` |
| wake_valid | output | 1 | Wake pulse |
| wake_mask | output | NNODE | Nodes to raise from nap to standby |
| err_ovf | output | 1 | Map hit a saturated counter (pulse) |
| err_unf | output | 1 | Unmap hit a zero counter (pulse) |

## Verification
The assertions take every input id to be in range: a process id below NPROC and a node id below NNODE. They also take `nap_mask` to be valid in the cycle of `sw_valid`, because the pulse-masking property compares against its value one cycle earlier. The map-sets property holds only when no unmap shares the cycle, so it is guarded on that case. The stimulus keeps every id within the default eight slots and sixteen nodes. It drives `nap_mask` together with each switch and drives inputs only between clock edges.

// File: rtl/node_activity_tracker.sv
module node_activity_tracker #(
  parameter int NPROC = 8,
  parameter int NNODE = 16,
  parameter int CW    = 16,
  localparam int PW   = $clog2(NPROC),
  localparam int NW   = $clog2(NNODE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             map_valid,
  input  logic [PW-1:0]    map_pid,
  input  logic [NW-1:0]    map_node,
  input  logic             unmap_valid,
  input  logic [PW-1:0]    unmap_pid,
  input  logic [NW-1:0]    unmap_node,
  input  logic             sw_valid,
  input  logic [PW-1:0]    sw_next_pid,
  input  logic [PW-1:0]    sw_after_pid,
  input  logic [NNODE-1:0] nap_mask,
  input  logic [PW-1:0]    qry_pid,
  output logic [NNODE-1:0] qry_mask,
  output logic             wake_valid,
  output logic [NNODE-1:0] wake_mask,
  output logic             err_ovf,
  output logic             err_unf
);
  localparam int NENT = NPROC * NNODE;
  localparam int IW   = PW + NW;

  logic [NENT-1:0][CW-1:0] cnt_q, cnt_d;
  logic [NENT-1:0]         act_q, act_d, ovf_v, unf_v;

  wire [IW-1:0] m_idx = {map_pid, map_node};
  wire [IW-1:0] u_idx = {unmap_pid, unmap_node};
  wire [IW-1:0] nx_base = {sw_next_pid, {NW{1'b0}}};
  wire [IW-1:0] af_base = {sw_after_pid, {NW{1'b0}}};
  wire [IW-1:0] qy_base = {qry_pid, {NW{1'b0}}};

  always_comb begin
    for (int i = 0; i < NENT; i++) begin
      logic hu, hm;
      logic [CW-1:0] c1;
      hu = unmap_valid && (u_idx == IW'(i));
      hm = map_valid && (m_idx == IW'(i));
      unf_v[i] = hu && (cnt_q[i] == '0);
      c1 = (hu && cnt_q[i] != '0) ? cnt_q[i] - 1'b1 : cnt_q[i];
      ovf_v[i] = hm && (&c1);
      cnt_d[i] = (hm && !(&c1)) ? c1 + 1'b1 : c1;
      act_d[i] = act_q[i] ? (cnt_d[i] != '0) : hm;
    end
  end

  assign qry_mask = act_q[qy_base +: NNODE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      act_q      <= '0;
      wake_valid <= 1'b0;
      wake_mask  <= '0;
      err_ovf    <= 1'b0;
      err_unf    <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      act_q      <= act_d;
      err_ovf    <= |ovf_v;
      err_unf    <= |unf_v;
      wake_valid <= sw_valid;
      wake_mask  <= sw_valid ? ((act_d[nx_base +: NNODE] | act_d[af_base +: NNODE]) & nap_mask) : '0;
    end
  end
endmodule

// File: rtl/node_activity_tracker_chk.sv
module node_activity_tracker_chk #(
  parameter int NENT  = 128,
  parameter int IW    = 7,
  parameter int NNODE = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             map_valid,
  input logic             unmap_valid,
  input logic             sw_valid,
  input logic [IW-1:0]    m_idx,
  input logic [IW-1:0]    u_idx,
  input logic [NNODE-1:0] nap_mask,
  input logic [NENT-1:0]  act_q,
  input logic             wake_valid,
  input logic [NNODE-1:0] wake_mask,
  input logic             err_unf
);
  a_r8_wake_follows_switch: assert property (@(posedge clk) disable iff (!rst_n)
    sw_valid |=> wake_valid);

  a_r11_wake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_valid |=> (!wake_valid && wake_mask == '0));

  a_r10_nap_only: assert property (@(posedge clk) disable iff (!rst_n)
    sw_valid |=> ((wake_mask & ~$past(nap_mask)) == '0));

  a_r2_map_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (map_valid && !unmap_valid) |=> act_q[$past(m_idx)]);

  a_r4_underflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (unmap_valid && !act_q[u_idx]) |=> err_unf);

  a_r6_few_bits_move: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act_q ^ $past(act_q)) <= 2);
endmodule

bind node_activity_tracker node_activity_tracker_chk #(.NENT(NENT), .IW(IW), .NNODE(NNODE)) u_chk (.*);

// File: tb/node_activity_tracker_tb.sv
`timescale 1ns/1ps
module node_activity_tracker_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic map_valid = 0, unmap_valid = 0, sw_valid = 0;
  logic [2:0] map_pid = 0, unmap_pid = 0, sw_next_pid = 0, sw_after_pid = 0, qry_pid = 0;
  logic [3:0] map_node = 0, unmap_node = 0;
  logic [15:0] nap_mask = 0;
  logic [15:0] qry_mask, wake_mask;
  logic wake_valid, err_ovf, err_unf;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  node_activity_tracker u_dut (.*);

  typedef struct packed {
    logic [3:0]  req;
    logic        mv; logic [2:0] mp; logic [3:0] mn;
    logic        uv; logic [2:0] up; logic [3:0] un;
    logic        sv; logic [2:0] np; logic [2:0] ap; logic [15:0] nap;
    logic [2:0]  qp;
    logic [15:0] eq;
    logic        ewv; logic [15:0] ew;
    logic        eo; logic eu;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{4'd2, 1'b1,3'd1,4'd3,  1'b0,3'd0,4'd0,  1'b0,3'd0,3'd0,16'h0000, 3'd1,16'h0008, 1'b0,16'h0000, 1'b0,1'b0}, // R2
    '{4'd3, 1'b1,3'd1,4'd3,  1'b0,3'd0,4'd0,  1'b0,3'd0,3'd0,16'h0000, 3'd1,16'h0008, 1'b0,16'h0000, 1'b0,1'b0}, // R3
    '{4'd3, 1'b0,3'd0,4'd0,  1'b1,3'd1,4'd3,  1'b0,3'd0,3'd0,16'h0000, 3'd1,16'h0008, 1'b0,16'h0000, 1'b0,1'b0}, // R3
    '{4'd3, 1'b0,3'd0,4'd0,  1'b1,3'd1,4'd3,  1'b0,3'd0,3'd0,16'h0000, 3'd1,16'h0000, 1'b0,16'h0000, 1'b0,1'b0}, // R3
    '{4'd4, 1'b0,3'd0,4'd0,  1'b1,3'd1,4'd3,  1'b0,3'd0,3'd0,16'h0000, 3'd1,16'h0000, 1'b0,16'h0000, 1'b0,1'b1}, // R4
    '{4'd6, 1'b1,3'd2,4'd0,  1'b0,3'd0,4'd0,  1'b0,3'd0,3'd0,16'h0000, 3'd2,16'h0001, 1'b0,16'h0000, 1'b0,1'b0}, // R6
    '{4'd6, 1'b1,3'd3,4'd15, 1'b0,3'd0,4'd0,  1'b0,3'd0,3'd0,16'h0000, 3'd2,16'h0001, 1'b0,16'h0000, 1'b0,1'b0}, // R6
    '{4'd6, 1'b0,3'd0,4'd0,  1'b0,3'd0,4'd0,  1'b0,3'd0,3'd0,16'h0000, 3'd3,16'h8000, 1'b0,16'h0000, 1'b0,1'b0}, // R6
    '{4'd7, 1'b1,3'd4,4'd5,  1'b1,3'd4,4'd5,  1'b0,3'd0,3'd0,16'h0000, 3'd4,16'h0020, 1'b0,16'h0000, 1'b0,1'b1}, // R7
    '{4'd9, 1'b1,3'd2,4'd7,  1'b0,3'd0,4'd0,  1'b1,3'd2,3'd3,16'hFFFF, 3'd2,16'h0081, 1'b1,16'h8081, 1'b0,1'b0}, // R8 R9
    '{4'd10,1'b0,3'd0,4'd0,  1'b0,3'd0,4'd0,  1'b1,3'd2,3'd4,16'h0021, 3'd4,16'h0020, 1'b1,16'h0021, 1'b0,1'b0}, // R10
    '{4'd11,1'b0,3'd0,4'd0,  1'b0,3'd0,4'd0,  1'b0,3'd0,3'd0,16'hFFFF, 3'd4,16'h0020, 1'b0,16'h0000, 1'b0,1'b0}, // R11
    '{4'd9, 1'b0,3'd0,4'd0,  1'b1,3'd3,4'd15, 1'b1,3'd3,3'd5,16'hFFFF, 3'd3,16'h0000, 1'b1,16'h0000, 1'b0,1'b0}  // R9
  };

  task automatic chk(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    map_valid = 0; unmap_valid = 0; sw_valid = 0;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    for (int p = 0; p < 8; p++) begin
      qry_pid = 3'(p); #0.1;
      chk(1, "reset qry_mask", qry_mask, 16'h0);
    end
    chk(1, "reset wake", {wake_valid, err_ovf, err_unf, 13'h0}, 16'h0);
    chk(1, "reset wake_mask", wake_mask, 16'h0);
    @(negedge clk) rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      map_valid = TBL[i].mv; map_pid = TBL[i].mp; map_node = TBL[i].mn;
      unmap_valid = TBL[i].uv; unmap_pid = TBL[i].up; unmap_node = TBL[i].un;
      sw_valid = TBL[i].sv; sw_next_pid = TBL[i].np; sw_after_pid = TBL[i].ap;
      nap_mask = TBL[i].nap; qry_pid = TBL[i].qp;
      @(posedge clk); #1;
      chk(int'(TBL[i].req), "qry_mask", qry_mask, TBL[i].eq);
      chk(int'(TBL[i].req), "wake_valid", 16'(wake_valid), 16'(TBL[i].ewv));
      chk(int'(TBL[i].req), "wake_mask", wake_mask, TBL[i].ew);
      chk(int'(TBL[i].req), "err_ovf", 16'(err_ovf), 16'(TBL[i].eo));
      chk(int'(TBL[i].req), "err_unf", 16'(err_unf), 16'(TBL[i].eu));
    end
    @(negedge clk) idle();

    // R5 saturation on process 0, node 9
    map_pid = 0; map_node = 9; qry_pid = 0; map_valid = 1;
    repeat (65535) @(posedge clk);
    @(negedge clk) map_valid = 0;
    chk(5, "full counter mask", qry_mask, 16'h0200);
    chk(5, "no ovf below top", 16'(err_ovf), 16'h0);
    map_valid = 1;
    @(posedge clk); #1;
    chk(5, "ovf flag at top", 16'(err_ovf), 16'h1);
    @(negedge clk) map_valid = 0;
    unmap_pid = 0; unmap_node = 9; unmap_valid = 1;
    repeat (65534) @(posedge clk);
    @(negedge clk) unmap_valid = 0;
    chk(5, "saturated count held", qry_mask, 16'h0200);
    unmap_valid = 1;
    @(posedge clk); #1;
    chk(5, "last unmap clears", qry_mask, 16'h0000);
    chk(5, "no unf at 1->0", 16'(err_unf), 16'h0);
    @(negedge clk) idle();

    // R1 reset again clears state
    rst_n = 0; qry_pid = 2;
    @(posedge clk); #1;
    chk(1, "reset clears mask", qry_mask, 16'h0);
    @(negedge clk) rst_n = 1;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule